// File: doc/BRIEF.md
# Interrupt Destination Resolver

This block takes the addressing part of an interrupt message (a 32-bit destination field, a physical/logical mode bit, a 2-bit shorthand and the index of the sending unit). It turns these into a delivery bitmask over a parameterised set of local interrupt units. Each unit supplies a present flag and its physical ID. It also supplies its logical ID, whether it runs in legacy 8-bit addressing or extended 32-bit addressing, and, for legacy logical matching, whether it uses the flat or the cluster model.

Alongside the mask, the block names one target for lowest-priority delivery: the lowest-indexed unit in the mask, plus a flag telling whether any unit was selected at all. A request is sampled on a valid strobe. Its mask, index and flag are registered and presented together with an output valid pulse one clock later. They then hold until the next strobe.

Top module: `irq_dest_resolver`

## Requirements
- R1: Physical mode, shorthand 0: a legacy unit is selected when its ID bits [7:0] equal destination bits [7:0]; the upper destination bits are ignored for it.
- R2: Physical mode, shorthand 0: an extended unit is selected only when its full 32-bit ID equals the 32-bit destination.
- R3: Physical mode, shorthand 0, destination exactly 0x000000FF: every legacy unit is selected in addition to the normal ID matches.
- R4: Physical mode, shorthand 0, destination 0xFFFFFFFF: every present unit is selected.
- R5: Logical mode, shorthand 0, destination 0xFFFFFFFF: every extended unit is selected, and legacy units are still matched by their own logical rule against destination bits [7:0].
- R6: Logical mode, legacy unit in the flat model (cluster flag 0): selected when destination[7:0] AND logical ID[7:0] is nonzero.
- R7: Logical mode, legacy unit in the cluster model (cluster flag 1): destination[7:4] must equal logical ID[7:4] or be 0xF, and destination[3:0] AND logical ID[3:0] must be nonzero.
- R8: Logical mode, extended unit: destination[31:16] must equal logical ID[31:16], and destination[15:0] AND logical ID[15:0] must be nonzero.
- R9: The shorthand encoding is 0 = use the destination, 1 = sender only, 2 = all units, 3 = all units except the sender; the sender is given by index.
- R10: The lowest-priority output is the lowest set index of the mask, with a found flag equal to the OR of the mask; with an empty mask the index reads 0.
- R11: A unit whose present flag is 0 at the strobe never appears in the mask, under any mode or shorthand.
- R12: Outputs update on the clock edge that samples the valid strobe, out_valid pulses high for exactly that cycle, and mask, index and flag hold their values while no strobe arrives; after reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_dest | input | 32 | Destination field |
| req_logical | input | 1 | 0 = physical, 1 = logical |
| req_shorthand | input | 2 | Shorthand override (see R9) |
| req_sender | input | IDX_W | Index of the sending unit |
| unit_present | input | NUM_UNITS | Unit exists |
| unit_extended | input | NUM_UNITS | Unit uses 32-bit addressing |
| unit_cluster | input | NUM_UNITS | Legacy logical model: 1 = cluster, 0 = flat |
| unit_phys_id | input | NUM_UNITS*32 | Physical IDs, unit i at bits [32i+31:32i] |
| unit_log_id | input | NUM_UNITS*32 | Logical IDs, same packing |
| out_valid | output | 1 | Result strobe |
| out_mask | output | NUM_UNITS | Delivery bitmask |
| out_lowest_idx | output | IDX_W | Lowest-priority target index |
| out_lowest_found | output | 1 | Mask is nonzero |

## Verification
The bench builds the resolver with eight units. That is few enough for the reference model to enumerate every unit per request, and enough to hold a mix of flat, cluster and extended units plus one absent unit. With eight units, the sender index can point both at a live unit and at the absent one. One extended unit's ID is chosen as 0xFF, so the legacy broadcast and a genuine extended match overlap. An empty-mask case exercises the found flag, and back-to-back strobes and idle gaps exercise the hold behaviour.

// File: rtl/irq_dest_pkg.sv
package irq_dest_pkg;

  typedef enum logic [1:0] {
    SH_DEST   = 2'd0,
    SH_SELF   = 2'd1,
    SH_ALL    = 2'd2,
    SH_OTHERS = 2'd3
  } shorthand_e;

  localparam logic [31:0] DEST_ALL_ONES   = 32'hFFFF_FFFF;
  localparam logic [31:0] DEST_LEGACY_ALL = 32'h0000_00FF;
  localparam logic [3:0]  CLUSTER_ANY     = 4'hF;

  function automatic logic phys_hit(input logic [31:0] dest,
                                    input logic [31:0] id,
                                    input logic        ext);
    if (dest == DEST_ALL_ONES)       return 1'b1;
    else if (ext)                    return id == dest;
    else if (dest == DEST_LEGACY_ALL) return 1'b1;
    else                             return id[7:0] == dest[7:0];
  endfunction

  function automatic logic logic_hit(input logic [31:0] dest,
                                     input logic [31:0] lid,
                                     input logic        ext,
                                     input logic        cluster);
    if (ext) begin
      if (dest == DEST_ALL_ONES) return 1'b1;
      return (dest[31:16] == lid[31:16]) && (|(dest[15:0] & lid[15:0]));
    end
    if (!cluster) return |(dest[7:0] & lid[7:0]);
    return ((dest[7:4] == CLUSTER_ANY) || (dest[7:4] == lid[7:4])) &&
           (|(dest[3:0] & lid[3:0]));
  endfunction

endpackage

// File: rtl/irq_unit_match.sv
module irq_unit_match
  import irq_dest_pkg::*;
(
  input  logic [31:0] dest,
  input  logic        logical,
  input  logic [1:0]  shorthand,
  input  logic        is_sender,
  input  logic        present,
  input  logic        ext,
  input  logic        cluster,
  input  logic [31:0] phys_id,
  input  logic [31:0] log_id,
  output logic        hit
);
  logic dest_hit;

  always_comb begin
    dest_hit = logical ? logic_hit(dest, log_id, ext, cluster)
                       : phys_hit(dest, phys_id, ext);
    unique case (shorthand_e'(shorthand))
      SH_DEST:   hit = present & dest_hit;
      SH_SELF:   hit = present & is_sender;
      SH_ALL:    hit = present;
      SH_OTHERS: hit = present & ~is_sender;
      default:   hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/irq_first_set.sv
module irq_first_set #(
  parameter int WIDTH = 32,
  localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic [WIDTH-1:0] vec,
  output logic [IDX_W-1:0] idx,
  output logic             found
);
  always_comb begin
    idx   = '0;
    found = |vec;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/irq_dest_resolver.sv
module irq_dest_resolver
  import irq_dest_pkg::*;
#(
  parameter int NUM_UNITS = 32,
  localparam int IDX_W = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic [31:0]            req_dest,
  input  logic                   req_logical,
  input  logic [1:0]             req_shorthand,
  input  logic [IDX_W-1:0]       req_sender,
  input  logic [NUM_UNITS-1:0]   unit_present,
  input  logic [NUM_UNITS-1:0]   unit_extended,
  input  logic [NUM_UNITS-1:0]   unit_cluster,
  input  logic [NUM_UNITS*32-1:0] unit_phys_id,
  input  logic [NUM_UNITS*32-1:0] unit_log_id,
  output logic                   out_valid,
  output logic [NUM_UNITS-1:0]   out_mask,
  output logic [IDX_W-1:0]       out_lowest_idx,
  output logic                   out_lowest_found
);
  logic [NUM_UNITS-1:0] sel_mask;
  logic [IDX_W-1:0]     first_idx;
  logic                 first_found;

  for (genvar g = 0; g < NUM_UNITS; g++) begin : g_unit
    irq_unit_match u_match (
      .dest      (req_dest),
      .logical   (req_logical),
      .shorthand (req_shorthand),
      .is_sender (req_sender == IDX_W'(g)),
      .present   (unit_present[g]),
      .ext       (unit_extended[g]),
      .cluster   (unit_cluster[g]),
      .phys_id   (unit_phys_id[g*32 +: 32]),
      .log_id    (unit_log_id[g*32 +: 32]),
      .hit       (sel_mask[g])
    );
  end

  irq_first_set #(.WIDTH(NUM_UNITS)) u_first (
    .vec   (sel_mask),
    .idx   (first_idx),
    .found (first_found)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid        <= 1'b0;
      out_mask         <= '0;
      out_lowest_idx   <= '0;
      out_lowest_found <= 1'b0;
    end else begin
      out_valid <= req_valid;
      if (req_valid) begin
        out_mask         <= sel_mask;
        out_lowest_idx   <= first_idx;
        out_lowest_found <= first_found;
      end
    end
  end

  // R12: one-cycle latency and hold
  p_latency_r12: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);
  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!out_valid && $stable(out_mask) && $stable(out_lowest_idx)));

  // R11: absent units never selected
  p_absent_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> ((out_mask & ~$past(unit_present)) == '0));

  // R4: physical all-ones covers every present unit
  p_bcast_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_logical && req_shorthand == 2'd0 && req_dest == 32'hFFFF_FFFF)
      |=> (out_mask == $past(unit_present)));

  // R9: sender-only selects at most one unit
  p_self_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_shorthand == 2'd1) |=> $onehot0(out_mask));

  // R10: chosen index is set and nothing below it is
  p_lowest_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_lowest_found) |->
      (out_mask[out_lowest_idx] &&
       ((out_mask & ((NUM_UNITS'(1) << out_lowest_idx) - NUM_UNITS'(1))) == '0)));
  p_found_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_lowest_found == (out_mask != '0)));
endmodule

// File: tb/irq_dest_resolver_tb.sv
module irq_dest_resolver_tb;
  localparam int N = 8;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [31:0] req_dest = '0;
  logic req_logical = 1'b0;
  logic [1:0] req_shorthand = '0;
  logic [IW-1:0] req_sender = '0;
  logic [N-1:0] unit_present = '0, unit_extended = '0, unit_cluster = '0;
  logic [N*32-1:0] unit_phys_id = '0, unit_log_id = '0;
  logic out_valid, out_lowest_found;
  logic [N-1:0] out_mask;
  logic [IW-1:0] out_lowest_idx;

  int checks = 0, failures = 0;
  bit done = 0;
  bit model_on = 0;
  string cur_tag = "R12", exp_tag = "R12";
  logic exp_valid = 0, exp_found = 0;
  logic [N-1:0] exp_mask = '0;
  int exp_idx = 0;

  always #10 clk = ~clk;

  irq_dest_resolver #(.NUM_UNITS(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dest(req_dest),
    .req_logical(req_logical), .req_shorthand(req_shorthand), .req_sender(req_sender),
    .unit_present(unit_present), .unit_extended(unit_extended), .unit_cluster(unit_cluster),
    .unit_phys_id(unit_phys_id), .unit_log_id(unit_log_id),
    .out_valid(out_valid), .out_mask(out_mask), .out_lowest_idx(out_lowest_idx),
    .out_lowest_found(out_lowest_found)
  );

  function automatic bit unit_selected(int i);
    logic [31:0] d, pid, lid;
    int d8, l8;
    d = req_dest;
    pid = unit_phys_id[i*32 +: 32];
    lid = unit_log_id[i*32 +: 32];
    d8 = int'(d % 256);
    l8 = int'(lid % 256);
    if (!unit_present[i]) return 0;
    if (req_shorthand == 2'd1) return i == int'(req_sender);
    if (req_shorthand == 2'd2) return 1;
    if (req_shorthand == 2'd3) return i != int'(req_sender);
    if (!req_logical) begin
      if (d == 32'hFFFFFFFF) return 1;
      if (unit_extended[i]) return pid == d;
      return (d == 32'd255) || (int'(pid % 256) == d8);
    end
    if (unit_extended[i])
      return (d == 32'hFFFFFFFF) ||
             ((d >> 16) == (lid >> 16) && ((d % 65536) & (lid % 65536)) != 0);
    if (!unit_cluster[i]) return (d8 & l8) != 0;
    return ((d8 / 16) == 15 || (d8 / 16) == (l8 / 16)) && ((d8 % 16) & (l8 % 16)) != 0;
  endfunction

  // Reference model: advances on each clock edge
  always @(posedge clk) begin
    if (!rst_n) begin
      exp_valid = 0; exp_mask = '0; exp_idx = 0; exp_found = 0;
    end else begin
      exp_valid = req_valid;
      if (req_valid) begin
        exp_tag = cur_tag;
        exp_found = 0; exp_idx = 0;
        for (int i = 0; i < N; i++) exp_mask[i] = unit_selected(i);
        for (int i = N - 1; i >= 0; i--) if (exp_mask[i]) begin exp_idx = i; exp_found = 1; end
      end else exp_tag = "R12";
    end
  end

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (model_on && !done) begin
      checks++;
      if (out_valid !== exp_valid || out_mask !== exp_mask ||
          out_lowest_found !== exp_found || int'(out_lowest_idx) != exp_idx) begin
        failures++;
        $display("FAIL %s: got v=%b mask=%b idx=%0d found=%b, expected v=%b mask=%b idx=%0d found=%b",
                 exp_tag, out_valid, out_mask, out_lowest_idx, out_lowest_found,
                 exp_valid, exp_mask, exp_idx, exp_found);
      end
    end
  end

  task automatic set_unit(int i, bit pres, bit ext, bit clus, logic [31:0] pid, logic [31:0] lid);
    unit_present[i] = pres; unit_extended[i] = ext; unit_cluster[i] = clus;
    unit_phys_id[i*32 +: 32] = pid; unit_log_id[i*32 +: 32] = lid;
  endtask

  task automatic send(string tag, bit lg, logic [1:0] sh, logic [31:0] d, int snd, int idle);
    @(negedge clk);
    cur_tag = tag; req_valid = 1; req_logical = lg; req_shorthand = sh;
    req_dest = d; req_sender = IW'(snd);
    @(negedge clk);
    req_valid = 0;
    req_dest = ~d;
    for (int k = 0; k < idle; k++) @(negedge clk);
  endtask

  initial begin
    set_unit(0, 1, 0, 0, 32'h03, 32'h01);
    set_unit(1, 1, 0, 0, 32'h05, 32'h06);
    set_unit(2, 1, 0, 1, 32'h10, 32'h21);
    set_unit(3, 1, 0, 1, 32'h11, 32'h32);
    set_unit(4, 1, 1, 0, 32'h0000_0104, 32'h0001_0002);
    set_unit(5, 1, 1, 0, 32'h0000_00FF, 32'h0001_0008);
    set_unit(6, 0, 0, 0, 32'h03, 32'hFF);
    set_unit(7, 1, 0, 1, 32'h07, 32'h24);
    repeat (3) @(negedge clk);
    // reset state (R12)
    checks++;
    if (out_valid !== 0 || out_mask !== '0 || out_lowest_idx !== '0 || out_lowest_found !== 0) begin
      failures++;
      $display("FAIL R12: reset outputs v=%b mask=%b idx=%0d found=%b, expected all 0",
               out_valid, out_mask, out_lowest_idx, out_lowest_found);
    end
    rst_n = 1;
    @(negedge clk);
    model_on = 1;
    send("R1",  0, 2'd0, 32'h0000_0003, 0, 1);
    send("R1",  0, 2'd0, 32'h0000_0105, 0, 2);
    send("R2",  0, 2'd0, 32'h0000_0104, 0, 1);
    send("R2",  0, 2'd0, 32'h0000_0204, 0, 1);
    send("R3",  0, 2'd0, 32'h0000_00FF, 0, 1);
    send("R4",  0, 2'd0, 32'hFFFF_FFFF, 0, 0);
    send("R5",  1, 2'd0, 32'hFFFF_FFFF, 0, 1);
    send("R6",  1, 2'd0, 32'h0000_0002, 0, 1);
    send("R7",  1, 2'd0, 32'h0000_0021, 0, 0);
    send("R7",  1, 2'd0, 32'h0000_00F4, 0, 1);
    send("R7",  1, 2'd0, 32'h0000_0018, 0, 1);
    send("R8",  1, 2'd0, 32'h0001_000A, 0, 1);
    send("R8",  1, 2'd0, 32'h0002_0002, 0, 1);
    send("R9",  0, 2'd1, 32'h0000_0000, 3, 0);
    send("R9",  0, 2'd2, 32'h0000_0000, 3, 0);
    send("R9",  0, 2'd3, 32'h0000_0000, 0, 1);
    send("R11", 0, 2'd1, 32'h0000_0000, 6, 1);
    send("R11", 0, 2'd3, 32'h0000_0000, 6, 1);
    send("R10", 1, 2'd0, 32'h0000_0080, 0, 3);
    set_unit(0, 0, 0, 0, 32'h03, 32'h01);
    send("R11", 0, 2'd2, 32'h0000_0000, 0, 1);
    send("R10", 1, 2'd0, 32'h0000_00F2, 0, 4);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL R12: watchdog expired, got running, expected finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule